// File: doc/BRIEF.md
# Quad X-Frame Motor Mixer

This block turns one collective thrust command and three axis corrections (roll, pitch and yaw) into four motor duty values for a quadcopter in the X layout. Every value at the ports is a signed Q8.8 number: 8 integer bits and 8 fraction bits in two's complement. Each motor adds or subtracts each axis correction according to its place on the frame. The result is then clamped, on that motor alone, into the duty window from 0% to the full-duty constant.

The mixer has no clock and no state. It sits between the axis controllers and the PWM stage, and the outputs follow the inputs in the same cycle. There is no handshake at the edges, so the stage around it must hold its inputs stable for as long as the outputs are in use. A motor that hits a bound is clamped on its own. The other three keep their exact mixed values and are never scaled down to match.

Top module: `quad_x_mixer`

## Requirements
- R1: `motor0_o` (front right) equals thrust − roll + pitch + yaw whenever that sum lies strictly between 0 and `DUTY_MAX`.
- R2: `motor1_o` (back left) equals thrust + roll − pitch + yaw whenever that sum lies strictly between 0 and `DUTY_MAX`.
- R3: `motor2_o` (front left) equals thrust + roll + pitch − yaw whenever that sum lies strictly between 0 and `DUTY_MAX`.
- R4: `motor3_o` (back right) equals thrust − roll − pitch − yaw whenever that sum lies strictly between 0 and `DUTY_MAX`.
- R5: Each sum is formed at 18 bits, so full-scale inputs never wrap. A true sum at or above `DUTY_MAX` yields `DUTY_MAX`, and a true sum at or below 0 yields 0, even when the 16-bit sum would have overflowed.
- R6: No motor output ever exceeds `DUTY_MAX`. The default is 0x0100, which is 1.0 in Q8.8 and stands for 100% duty.
- R7: No motor output is ever below 0. A negative or zero sum gives 0x0000.
- R8: Clamping one motor leaves the other motors' values unchanged. Each of them still equals its own mixed sum.
- R9: The block is combinational. The outputs reflect new inputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| thrust_i | input | 16 | Collective thrust command, signed Q8.8 |
| roll_i | input | 16 | Saturated roll correction, signed Q8.8 |
| pitch_i | input | 16 | Saturated pitch correction, signed Q8.8 |
| yaw_i | input | 16 | Saturated yaw correction, signed Q8.8 |
| motor0_o | output | 16 | Front-right duty, signed Q8.8, from 0 to DUTY_MAX |
| motor1_o | output | 16 | Back-left duty, signed Q8.8, from 0 to DUTY_MAX |
| motor2_o | output | 16 | Front-left duty, signed Q8.8, from 0 to DUTY_MAX |
| motor3_o | output | 16 | Back-right duty, signed Q8.8, from 0 to DUTY_MAX |

## Verification
The bound checker re-evaluates the duty window and the mixing identities whenever an input changes. It compares each motor against a wide integer sum, so it catches a wrong sign, a wrapped sum or a missing clamp on any input the bench applies. The bench scenarios cover what those checks cannot choose for themselves. They drive all eight sign combinations through the matrix, push full-scale inputs that would wrap a 16-bit adder, and set up patterns where one or two motors saturate while their neighbours must keep their exact values.

// File: rtl/quad_mix_pkg.sv
`timescale 1ns/1ps
package quad_mix_pkg;
  localparam int MOTORS = 4;
  // Bit m set: motor m subtracts that axis correction.
  localparam logic [MOTORS-1:0] ROLL_NEG_MASK  = 4'b1001;
  localparam logic [MOTORS-1:0] PITCH_NEG_MASK = 4'b1010;
  localparam logic [MOTORS-1:0] YAW_NEG_MASK   = 4'b1100;
endpackage

// File: rtl/quad_mix_sum.sv
`timescale 1ns/1ps
module quad_mix_sum #(
  parameter int DATA_W = 16,
  parameter int SUM_W  = DATA_W + 2,
  parameter bit NEG_R  = 1'b0,
  parameter bit NEG_P  = 1'b0,
  parameter bit NEG_Y  = 1'b0
) (
  input  logic signed [DATA_W-1:0] thr_i,
  input  logic signed [DATA_W-1:0] roll_i,
  input  logic signed [DATA_W-1:0] pitch_i,
  input  logic signed [DATA_W-1:0] yaw_i,
  output logic signed [SUM_W-1:0]  sum_o
);
  localparam int EXT = SUM_W - DATA_W;

  logic signed [SUM_W-1:0] thr_x, roll_x, pitch_x, yaw_x;
  logic signed [SUM_W-1:0] roll_t, pitch_t, yaw_t;

  assign thr_x   = {{EXT{thr_i[DATA_W-1]}},   thr_i};
  assign roll_x  = {{EXT{roll_i[DATA_W-1]}},  roll_i};
  assign pitch_x = {{EXT{pitch_i[DATA_W-1]}}, pitch_i};
  assign yaw_x   = {{EXT{yaw_i[DATA_W-1]}},   yaw_i};

  generate
    if (NEG_R) begin : g_roll_sub
      assign roll_t = -roll_x;
    end else begin : g_roll_add
      assign roll_t = roll_x;
    end
    if (NEG_P) begin : g_pitch_sub
      assign pitch_t = -pitch_x;
    end else begin : g_pitch_add
      assign pitch_t = pitch_x;
    end
    if (NEG_Y) begin : g_yaw_sub
      assign yaw_t = -yaw_x;
    end else begin : g_yaw_add
      assign yaw_t = yaw_x;
    end
  endgenerate

  assign sum_o = thr_x + roll_t + pitch_t + yaw_t;
endmodule

// File: rtl/quad_duty_clamp.sv
`timescale 1ns/1ps
module quad_duty_clamp #(
  parameter int DATA_W   = 16,
  parameter int SUM_W    = DATA_W + 2,
  parameter int DUTY_MAX = 256
) (
  input  logic signed [SUM_W-1:0]  sum_i,
  output logic signed [DATA_W-1:0] duty_o
);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'(DUTY_MAX);
  localparam logic signed [SUM_W-1:0] ZERO_S = '0;

  always_comb begin
    if (sum_i >= MAX_S) begin
      duty_o = MAX_S[DATA_W-1:0];
    end else if (sum_i <= ZERO_S) begin
      duty_o = '0;
    end else begin
      duty_o = sum_i[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/quad_x_mixer.sv
`timescale 1ns/1ps
module quad_x_mixer #(
  parameter int DATA_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int DUTY_MAX = 1 << FRAC_W
) (
  input  logic signed [DATA_W-1:0] thrust_i,
  input  logic signed [DATA_W-1:0] roll_i,
  input  logic signed [DATA_W-1:0] pitch_i,
  input  logic signed [DATA_W-1:0] yaw_i,
  output logic signed [DATA_W-1:0] motor0_o,
  output logic signed [DATA_W-1:0] motor1_o,
  output logic signed [DATA_W-1:0] motor2_o,
  output logic signed [DATA_W-1:0] motor3_o
);
  import quad_mix_pkg::*;

  localparam int SUM_W = DATA_W + 2;

  logic signed [SUM_W-1:0]  sum_w  [MOTORS];
  logic signed [DATA_W-1:0] duty_w [MOTORS];

  generate
    for (genvar m = 0; m < MOTORS; m++) begin : g_motor
      quad_mix_sum #(
        .DATA_W (DATA_W),
        .SUM_W  (SUM_W),
        .NEG_R  (ROLL_NEG_MASK[m]),
        .NEG_P  (PITCH_NEG_MASK[m]),
        .NEG_Y  (YAW_NEG_MASK[m])
      ) sum_i (
        .thr_i   (thrust_i),
        .roll_i  (roll_i),
        .pitch_i (pitch_i),
        .yaw_i   (yaw_i),
        .sum_o   (sum_w[m])
      );

      quad_duty_clamp #(
        .DATA_W   (DATA_W),
        .SUM_W    (SUM_W),
        .DUTY_MAX (DUTY_MAX)
      ) clamp_i (
        .sum_i  (sum_w[m]),
        .duty_o (duty_w[m])
      );
    end
  endgenerate

  assign motor0_o = duty_w[0];
  assign motor1_o = duty_w[1];
  assign motor2_o = duty_w[2];
  assign motor3_o = duty_w[3];
endmodule

// File: rtl/quad_x_mixer_chk.sv
`timescale 1ns/1ps
module quad_x_mixer_chk #(
  parameter int DATA_W   = 16,
  parameter int DUTY_MAX = 256
) (
  input logic signed [DATA_W-1:0] thrust_i,
  input logic signed [DATA_W-1:0] roll_i,
  input logic signed [DATA_W-1:0] pitch_i,
  input logic signed [DATA_W-1:0] yaw_i,
  input logic signed [DATA_W-1:0] motor0_o,
  input logic signed [DATA_W-1:0] motor1_o,
  input logic signed [DATA_W-1:0] motor2_o,
  input logic signed [DATA_W-1:0] motor3_o
);
  int ref_s [4];
  int out_s [4];

  always_comb begin
    ref_s[0] = int'(thrust_i) - int'(roll_i) + int'(pitch_i) + int'(yaw_i);
    ref_s[1] = int'(thrust_i) + int'(roll_i) - int'(pitch_i) + int'(yaw_i);
    ref_s[2] = int'(thrust_i) + int'(roll_i) + int'(pitch_i) - int'(yaw_i);
    ref_s[3] = int'(thrust_i) - int'(roll_i) - int'(pitch_i) - int'(yaw_i);
    out_s[0] = int'(motor0_o);
    out_s[1] = int'(motor1_o);
    out_s[2] = int'(motor2_o);
    out_s[3] = int'(motor3_o);
  end

  always_comb begin
    assert_mix_front_right_R1: assert (!(ref_s[0] > 0 && ref_s[0] < DUTY_MAX) || out_s[0] == ref_s[0])
      else $error("motor0 mix mismatch");
    assert_mix_back_left_R2: assert (!(ref_s[1] > 0 && ref_s[1] < DUTY_MAX) || out_s[1] == ref_s[1])
      else $error("motor1 mix mismatch");
    assert_mix_front_left_R3: assert (!(ref_s[2] > 0 && ref_s[2] < DUTY_MAX) || out_s[2] == ref_s[2])
      else $error("motor2 mix mismatch");
    assert_mix_back_right_R4: assert (!(ref_s[3] > 0 && ref_s[3] < DUTY_MAX) || out_s[3] == ref_s[3])
      else $error("motor3 mix mismatch");
    for (int m = 0; m < 4; m++) begin
      assert_no_wrap_high_R5: assert (ref_s[m] < DUTY_MAX || out_s[m] == DUTY_MAX)
        else $error("motor %0d high sum not clamped", m);
      assert_no_wrap_low_R5: assert (ref_s[m] > 0 || out_s[m] == 0)
        else $error("motor %0d low sum not zeroed", m);
      assert_duty_ceiling_R6: assert (out_s[m] <= DUTY_MAX)
        else $error("motor %0d above ceiling", m);
      assert_duty_floor_R7: assert (out_s[m] >= 0)
        else $error("motor %0d below zero", m);
    end
  end
endmodule

bind quad_x_mixer quad_x_mixer_chk #(
  .DATA_W   (DATA_W),
  .DUTY_MAX (DUTY_MAX)
) chk_i (
  .thrust_i (thrust_i),
  .roll_i   (roll_i),
  .pitch_i  (pitch_i),
  .yaw_i    (yaw_i),
  .motor0_o (motor0_o),
  .motor1_o (motor1_o),
  .motor2_o (motor2_o),
  .motor3_o (motor3_o)
);

// File: tb/quad_x_mixer_tb_top.sv
`timescale 1ns/1ps
module quad_x_mixer_tb_top;
  localparam int W   = 16;
  localparam int MAX = 256;

  typedef struct {
    logic [3:0][W-1:0] exp;
    string             req;
  } item_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic signed [W-1:0] thr, rol, pit, yaw;
  logic signed [W-1:0] m0, m1, m2, m3;

  quad_x_mixer dut_i (
    .thrust_i (thr), .roll_i (rol), .pitch_i (pit), .yaw_i (yaw),
    .motor0_o (m0), .motor1_o (m1), .motor2_o (m2), .motor3_o (m3)
  );

  item_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  function automatic logic [W-1:0] clampv(int s);
    if (s >= MAX) return W'(MAX);
    if (s <= 0) return '0;
    return W'(s);
  endfunction

  task automatic drive(int t, int r, int p, int y, string req);
    item_t it;
    @(posedge clk);
    #1;
    thr = W'(t); rol = W'(r); pit = W'(p); yaw = W'(y);
    it.exp[0] = clampv(t - r + p + y);
    it.exp[1] = clampv(t + r - p + y);
    it.exp[2] = clampv(t + r + p - y);
    it.exp[3] = clampv(t - r - p - y);
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: compares the design outputs away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        logic [3:0][W-1:0] act;
        it = sb_q.pop_front();
        act[0] = m0; act[1] = m1; act[2] = m2; act[3] = m3;
        for (int m = 0; m < 4; m++) begin
          total++;
          if (act[m] !== it.exp[m]) begin
            bad++;
            $display("FAIL %s motor%0d actual=%h expected=%h", it.req, m, act[m], it.exp[m]);
          end
        end
      end
    end
  end

  initial begin
    thr = '0; rol = '0; pit = '0; yaw = '0;
    // All-zero inputs: every duty is zero (R7)
    drive(0, 0, 0, 0, "R7 idle zero");
    // Every sign combination of the axes, all sums in range (R1 R2 R3 R4 R9)
    for (int c = 0; c < 8; c++) begin
      int r, p, y;
      r = c[0] ? -16 : 16;
      p = c[1] ? -32 : 32;
      y = c[2] ? -64 : 64;
      drive(128, r, p, y, "R1 R2 R3 R4 sign matrix");
    end
    // Single-axis patterns (R1 R2 R3 R4)
    drive(100, 20, 0, 0, "R1 R4 roll only");
    drive(100, 0, 20, 0, "R2 R3 pitch only");
    drive(100, 0, 0, 20, "R4 yaw only");
    // Upper clamp (R6)
    drive(240, 32, -32, 16, "R6 upper clamp");
    drive(256, 0, 0, 0, "R6 exactly full duty");
    drive(255, 0, 0, 0, "R6 just below full duty");
    // Lower clamp (R7)
    drive(16, 32, 32, 32, "R7 lower clamp");
    drive(-100, 0, 0, 0, "R7 negative thrust");
    drive(1, 0, 0, 0, "R7 smallest positive");
    // Full-scale inputs that would wrap a 16-bit sum (R5)
    drive(32767, 32767, 32767, 32767, "R5 high no wrap");
    drive(-32768, 32767, 32767, 32767, "R5 low no wrap");
    drive(-32768, -32768, -32768, -32768, "R5 negative full scale");
    drive(32767, -32768, -32768, -32768, "R5 mixed full scale");
    // Independent clamping: saturated motors must not disturb the others (R8)
    drive(192, -128, 0, 0, "R8 m0 m3 high others exact");
    drive(64, 0, 0, 96, "R8 m2 m3 low others exact");
    drive(128, 200, 0, 0, "R8 m0 m3 low m1 m2 high");
    // Back-to-back changes settle each cycle (R9)
    drive(50, 10, 5, 1, "R9 combinational step a");
    drive(60, -10, -5, -1, "R9 combinational step b");
    repeat (4) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20000 * 5);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule